// File: doc/BRIEF.md
# Leaf Reset Consistency Checker

This block watches one leaf reset, the parent reset that feeds it, and a software reset request that is already synchronous to the checker's clock. It raises an error when the leaf goes into reset without a legitimate cause: the parent reset asserting, or software asking for that leaf to reset.

Both reset inputs are asynchronous to the checker. Each one sets a capture flag asynchronously, so even a very short reset pulse is recorded. The flag is then passed through a synchronizer into the local clock domain. The two synchronized indications can arrive in either order, up to the synchronizer skew apart. A small state machine therefore waits a bounded number of local cycles for the missing partner before it declares a fault. Once a legitimate reset has been seen, the checker waits for both resets to release, clears its flags and rearms. An error is held until the local reset.

Top module: `leaf_rst_chk`

## Requirements
- R1: When the parent and leaf resets assert together, no error is raised.
- R2: If the leaf is seen asserted before the parent, the checker waits for the parent. A parent indication that arrives within the timeout window raises no error.
- R3: If the parent is seen asserted before the leaf, the checker waits for the leaf. A leaf indication that arrives within the timeout window raises no error.
- R4: A wait that lasts TIMEOUT local cycles (default 4) without its partner indication raises the error. This applies to a leaf that asserts alone, a parent that asserts alone, and a partner that comes too late. Measured from an input driven just after a falling clock edge, err_o rises after the 7th following rising edge.
- R5: A one-cycle high pulse on sw_rst_req_i is held as a legitimate cause. A leaf assertion that follows it raises no error. A software request that is not followed by a leaf assertion within the timeout raises the error.
- R6: After a legitimate reset, once both resets are released, the flags clear and the checker returns to idle. A later leaf assertion on its own is detected again.
- R7: err_o is sticky. It stays high after both resets release and clears only when rst_ni is asserted.
- R8: While rst_ni is low, and after it releases, err_o is 0.
- R9: A leaf reset pulse shorter than one local clock period is still captured and is checked like a long one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local checker clock |
| rst_ni | input | 1 | Local active-low asynchronous reset |
| parent_rst_ni | input | 1 | Parent reset, active low, asynchronous |
| leaf_rst_ni | input | 1 | Leaf reset under check, active low, asynchronous |
| sw_rst_req_i | input | 1 | Software reset request for the leaf, local clock domain |
| err_o | output | 1 | Sticky consistency error |

## Verification
A reset edge reaches the state machine after the capture flag and two synchronizer stages, so the first decision lands on the 3rd rising edge after the stimulus. With the default timeout of 4, an unanswered indication shows up on err_o after the 7th rising edge. A partner that arrives up to 4 edges late is accepted; one that arrives 5 edges late is not. The driver stamps each expected err_o value with the absolute cycle in which it is due. It stamps the 6th edge (still 0) and the 7th edge (now 1), and late points for the runs that must stay clean. The monitor compares only in those cycles, sampling on the falling edge.

// File: rtl/leaf_rst_chk_pkg.sv
package leaf_rst_chk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_PARENT,
    ST_WAIT_LEAF,
    ST_WAIT_RELEASE,
    ST_ERROR
  } chk_state_e;
endpackage

// File: rtl/rst_flag_sync.sv
module rst_flag_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_rst_ni,
  input  logic clr_i,
  output logic flag_o,
  output logic active_o
);
  logic                   flag_q;
  logic [SYNC_STAGES-1:0] flag_sync_q;
  logic [SYNC_STAGES-1:0] lvl_sync_q;

  // capture flag: set by the source reset, cleared in the local domain
  always_ff @(posedge clk_i or negedge src_rst_ni) begin
    if (!src_rst_ni)            flag_q <= 1'b1;
    else if (!rst_ni || clr_i)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_sync_q <= '0;
      lvl_sync_q  <= '0;
    end else begin
      flag_sync_q <= {flag_sync_q[SYNC_STAGES-2:0], flag_q};
      lvl_sync_q  <= {lvl_sync_q[SYNC_STAGES-2:0], ~src_rst_ni};
    end
  end

  assign flag_o   = flag_sync_q[SYNC_STAGES-1];
  assign active_o = lvl_sync_q[SYNC_STAGES-1];

  assert_capture_feeds_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_sync_q[0]) |-> $past(flag_q));
endmodule

// File: rtl/chk_timer.sv
module chk_timer #(
  parameter int unsigned TIMEOUT = 4,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  assign expired_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  always @(posedge clk_i) begin
    if (rst_ni) assert_cnt_bound_R4: assert (cnt_q <= LAST);
  end
endmodule

// File: rtl/chk_fsm.sv
module chk_fsm
  import leaf_rst_chk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       leaf_s_i,
  input  logic       parent_s_i,
  input  logic       leaf_act_i,
  input  logic       parent_act_i,
  input  logic       sw_req_i,
  input  logic       expired_i,
  output logic       run_o,
  output logic       clr_o,
  output logic       err_o
);
  chk_state_e state_q, state_d;
  logic       sw_seen_q;
  logic       released;
  logic       cause;

  assign released = !leaf_act_i && !parent_act_i;
  assign cause    = parent_s_i || sw_seen_q;
  assign clr_o    = (state_q == ST_WAIT_RELEASE) && released;
  assign run_o    = (state_q == ST_WAIT_PARENT) || (state_q == ST_WAIT_LEAF);
  assign err_o    = (state_q == ST_ERROR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sw_seen_q <= 1'b0;
    else if (sw_req_i) sw_seen_q <= 1'b1;
    else if (clr_o)    sw_seen_q <= 1'b0;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (leaf_s_i && cause) state_d = ST_WAIT_RELEASE;
        else if (leaf_s_i)     state_d = ST_WAIT_PARENT;
        else if (cause)        state_d = ST_WAIT_LEAF;
      end
      ST_WAIT_PARENT: begin
        if (cause)          state_d = ST_WAIT_RELEASE;
        else if (expired_i) state_d = ST_ERROR;
      end
      ST_WAIT_LEAF: begin
        if (leaf_s_i)       state_d = ST_WAIT_RELEASE;
        else if (expired_i) state_d = ST_ERROR;
      end
      ST_WAIT_RELEASE: begin
        if (released && !leaf_s_i && !parent_s_i && !sw_seen_q) state_d = ST_IDLE;
      end
      ST_ERROR: state_d = ST_ERROR;
      default:  state_d = ST_ERROR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ERROR |=> state_q == ST_ERROR);
  assert_no_direct_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |=> state_q != ST_ERROR);
  assert_release_needs_leaf_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_WAIT_RELEASE) |-> $past(leaf_s_i));
endmodule

// File: rtl/leaf_rst_chk.sv
module leaf_rst_chk #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic parent_rst_ni,
  input  logic leaf_rst_ni,
  input  logic sw_rst_req_i,
  output logic err_o
);
  localparam int unsigned NSRC = 2; // 0: leaf, 1: parent

  logic [NSRC-1:0] src_n, flag_s, act_s;
  logic            clr, run, expired;

  assign src_n = {parent_rst_ni, leaf_rst_ni};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    rst_flag_sync #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_rst_ni (src_n[i]),
      .clr_i      (clr),
      .flag_o     (flag_s[i]),
      .active_o   (act_s[i])
    );
  end

  chk_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .expired_o (expired)
  );

  chk_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .leaf_s_i     (flag_s[0]),
    .parent_s_i   (flag_s[1]),
    .leaf_act_i   (act_s[0]),
    .parent_act_i (act_s[1]),
    .sw_req_i     (sw_rst_req_i),
    .expired_i    (expired),
    .run_o        (run),
    .clr_o        (clr),
    .err_o        (err_o)
  );

  assert_err_after_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(run && expired));
endmodule

// File: tb/leaf_rst_chk_bench.sv
module leaf_rst_chk_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic parent_rst_ni = 1'b1, leaf_rst_ni = 1'b1, sw_rst_req_i = 1'b0;
  logic err_o;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int at; logic val; string tag; } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  leaf_rst_chk u_leaf_rst_chk (
    .clk_i(clk), .rst_ni(rst_ni), .parent_rst_ni(parent_rst_ni),
    .leaf_rst_ni(leaf_rst_ni), .sw_rst_req_i(sw_rst_req_i), .err_o(err_o)
  );

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      if (q[0].at == cyc) begin
        checks++;
        if (err_o !== q[0].val) begin
          errors++;
          $display("FAIL %s cycle %0d: err_o=%b expected %b", q[0].tag, cyc, err_o, q[0].val);
        end
      end
      void'(q.pop_front());
    end
  end

  task automatic expect_at(int at, logic v, string tag);
    exp_t e; e.at = at; e.val = v; e.tag = tag; q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    step(1);
    parent_rst_ni = 1'b1; leaf_rst_ni = 1'b1; sw_rst_req_i = 1'b0;
    step(3);
    rst_ni = 1'b0;
    step(3);
    expect_at(cyc, 1'b0, "R8");
    step(1);
    rst_ni = 1'b1;
    expect_at(cyc + 1, 1'b0, "R8");
    step(2);
  endtask

  initial begin
    int c;
    step(3);
    rst_ni = 1'b1;
    expect_at(cyc + 1, 1'b0, "R8");
    step(2);

    // R1 then R6 then R7
    c = cyc; parent_rst_ni = 0; leaf_rst_ni = 0;
    expect_at(c + 3, 0, "R1"); expect_at(c + 8, 0, "R1");
    step(6); parent_rst_ni = 1; leaf_rst_ni = 1;
    step(10);
    c = cyc; leaf_rst_ni = 0;
    expect_at(c + 6, 0, "R6"); expect_at(c + 7, 1, "R6");
    step(9); leaf_rst_ni = 1;
    expect_at(c + 20, 1, "R7");
    step(12);
    do_reset();

    // R2 parent 4 cycles late: accepted
    c = cyc; leaf_rst_ni = 0; step(4); parent_rst_ni = 0;
    expect_at(c + 8, 0, "R2"); expect_at(c + 12, 0, "R2");
    step(10);
    do_reset();

    // R4 parent 5 cycles late: error
    c = cyc; leaf_rst_ni = 0; step(5); parent_rst_ni = 0;
    expect_at(c + 6, 0, "R4"); expect_at(c + 7, 1, "R4");
    step(8);
    do_reset();

    // R3 leaf 4 cycles late: accepted
    c = cyc; parent_rst_ni = 0; step(4); leaf_rst_ni = 0;
    expect_at(c + 8, 0, "R3"); expect_at(c + 12, 0, "R3");
    step(10);
    do_reset();

    // R4 parent alone
    c = cyc; parent_rst_ni = 0;
    expect_at(c + 6, 0, "R4"); expect_at(c + 7, 1, "R4");
    step(9);
    do_reset();

    // R5 software request then leaf
    c = cyc; sw_rst_req_i = 1; step(1); sw_rst_req_i = 0; leaf_rst_ni = 0;
    expect_at(c + 6, 0, "R5"); expect_at(c + 10, 0, "R5");
    step(6); leaf_rst_ni = 1; step(10);
    expect_at(cyc + 1, 0, "R5");
    step(2);
    do_reset();

    // R5 software request with no leaf
    c = cyc; sw_rst_req_i = 1; step(1); sw_rst_req_i = 0;
    expect_at(c + 5, 0, "R5"); expect_at(c + 6, 1, "R5");
    step(8);
    do_reset();

    // R9 short leaf glitch
    c = cyc; leaf_rst_ni = 0; #2; leaf_rst_ni = 1;
    expect_at(c + 6, 0, "R9"); expect_at(c + 7, 1, "R9");
    step(9);
    do_reset();

    step(3);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule